// File: doc/BRIEF.md
# Oscillator-Driven Nanosecond Time-of-Day Counter

This block keeps a free-running time of day in nanoseconds. On every cycle of its 125 MHz reference clock it adds a programmable fixed-point step to an accumulator. The accumulator holds a 44-bit whole-nanosecond count and 28 fractional bits below it. With the reset step of 0x8000_0000 the count advances by exactly 8 ns per cycle. Software trims the rate by writing a step slightly above or below nominal, freezes time by writing a zero step, and sets the time by writing its three fields.

A 32-bit register bus with four word registers gives access to the counter. Word 0 holds the low field `ns[3:0]`, word 1 the middle field `ns[35:4]`, word 2 the top field `ns[43:36]` and word 3 the step. The top field is read back in bits [7:0] of word 2, but it is written through bits [15:8]. When word 2 is read, the middle field is captured into a shadow, and the next read of word 1 returns that shadow. A 40-bit time read as "top, then middle" is therefore coherent even if a carry crosses between the two fields.

Top module: `tod_nco_counter`

## Requirements
- R1: After synchronous active-high reset, `time_ns` is 0 and word 3 reads 0x8000_0000.
- R2: The step is unsigned with 28 fractional bits, so 0x8000_0000 means 8.0 ns. In each cycle without a time write, the accumulator adds the step, and with the nominal step `time_ns` rises by 8 per cycle.
- R3: Fractional steps accumulate. Starting from a whole value with a step of 0x8800_0000 (8.5 ns), the count advances 8, 9, 8, 9 ns in turn.
- R4: The count wraps modulo 2^44. From 0xFFF_FFFF_FFFF with the nominal step, the next value is 7.
- R5: With a step of zero, `time_ns` holds its value. After a nonzero step is written, counting resumes from the held value.
- R6: A write to word 0 loads `ns[3:0]` from data bits [3:0] and clears the fractional bits. A read of word 0 returns `ns[3:0]` in bits [3:0] with zeros above.
- R7: A write to word 1 loads `ns[35:4]` from all 32 data bits and leaves `ns[3:0]` and `ns[43:36]` unchanged.
- R8: A write to word 2 loads `ns[43:36]` from data bits [15:8]. A read of word 2 returns `ns[43:36]` in bits [7:0] with zeros in bits [31:8].
- R9: A time-field write takes effect at the next clock edge and replaces that cycle's step addition. Counting continues from the written value in the cycle after.
- R10: A read of word 2 snapshots `ns[35:4]`. The next read of word 1 returns the snapshot and consumes it. With no snapshot pending, or after any time-field write, a read of word 1 returns the live middle field.
- R11: A write to word 3 loads the step, which is used from the following edge on. The cycle of the write still uses the old step. Word 3 reads back the stored step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives snapshot side effects) |
| reg_word | input | 2 | Word select: 0 low, 1 middle, 2 top, 3 step |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected word, combinational |
| time_ns | output | 44 | Current whole-nanosecond time |

## Verification
The assertions check the following on every cycle: a zero step with no write keeps the time stable, each field write lands in its own bits and leaves the others alone, the low-field write clears the fraction, unused read bits of word 2 are zero, and a word-2 read captures the middle field. Only the bench scenarios can show the arithmetic results against independently computed values. These are the 8 ns nominal progression, the 8/9 alternation of a fractional step, the wrap from the 44-bit maximum to 7, the one-cycle lag of a step write, and the coherent middle value returned several cycles after a word-2 read.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int NS_W     = 44;
    localparam int FRAC_W   = 28;
    localparam int STEP_W   = 32;
    localparam int DATA_W   = 32;
    localparam int ACC_W    = NS_W + FRAC_W;
    localparam int LOW_W    = 4;
    localparam int MID_W    = 32;
    localparam int TOP_W    = NS_W - LOW_W - MID_W;
    localparam int TOP_WR_LSB = 8;

    typedef enum logic [1:0] {
        W_LOW  = 2'd0,
        W_MID  = 2'd1,
        W_TOP  = 2'd2,
        W_STEP = 2'd3
    } word_e;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } acc_t;
endpackage

// File: rtl/tod_accum.sv
module tod_accum
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] step,
    input  logic              ld_low,
    input  logic              ld_mid,
    input  logic              ld_top,
    input  logic [LOW_W-1:0]  low_val,
    input  logic [MID_W-1:0]  mid_val,
    input  logic [TOP_W-1:0]  top_val,
    output logic [NS_W-1:0]   time_ns
);
    acc_t acc_d, acc_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum   = acc_q + ACC_W'(step);
        acc_d = acc_q;
        if (ld_low || ld_mid || ld_top) begin
            if (ld_low) begin
                acc_d.ns[LOW_W-1:0] = low_val;
                acc_d.frac          = '0;
            end
            if (ld_mid) acc_d.ns[LOW_W+MID_W-1:LOW_W] = mid_val;
            if (ld_top) acc_d.ns[NS_W-1:LOW_W+MID_W]  = top_val;
        end else begin
            acc_d = acc_t'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign time_ns = acc_q.ns;

    // R5: zero step without a write freezes the time
    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (step == '0 && !ld_low && !ld_mid && !ld_top) |=> $stable(acc_q));

    // R6: low load lands in its bits and clears the fraction
    p_low_load_r6: assert property (@(posedge clk) disable iff (rst)
        ld_low |=> (acc_q.ns[LOW_W-1:0] == $past(low_val)) && (acc_q.frac == '0));

    // R7: a middle-only write leaves the low and top fields alone
    p_mid_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_mid && !ld_low && !ld_top) |=>
        (acc_q.ns[LOW_W-1:0] == $past(acc_q.ns[LOW_W-1:0])) &&
        (acc_q.ns[NS_W-1:LOW_W+MID_W] == $past(acc_q.ns[NS_W-1:LOW_W+MID_W])));

    // R8: top load lands in the top bits
    p_top_load_r8: assert property (@(posedge clk) disable iff (rst)
        ld_top |=> acc_q.ns[NS_W-1:LOW_W+MID_W] == $past(top_val));
endmodule

// File: rtl/tod_regif.sv
module tod_regif
    import tod_pkg::*;
#(
    parameter logic [STEP_W-1:0] STEP_RST = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        reg_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NS_W-1:0]   time_ns,
    output logic [DATA_W-1:0] rd_data,
    output logic [STEP_W-1:0] step,
    output logic              ld_low,
    output logic              ld_mid,
    output logic              ld_top,
    output logic [LOW_W-1:0]  low_val,
    output logic [MID_W-1:0]  mid_val,
    output logic [TOP_W-1:0]  top_val
);
    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [MID_W-1:0]  shadow;
        logic              shadow_vld;
    } regs_t;

    regs_t r_d, r_q;
    word_e sel;
    logic  [MID_W-1:0] mid_live;

    assign sel      = word_e'(reg_word);
    assign mid_live = time_ns[LOW_W+MID_W-1:LOW_W];
    assign ld_low   = wr_en && (sel == W_LOW);
    assign ld_mid   = wr_en && (sel == W_MID);
    assign ld_top   = wr_en && (sel == W_TOP);
    assign low_val  = wr_data[LOW_W-1:0];
    assign mid_val  = wr_data;
    assign top_val  = wr_data[TOP_WR_LSB+TOP_W-1:TOP_WR_LSB];
    assign step     = r_q.step;

    always_comb begin
        r_d = r_q;
        if (wr_en && sel == W_STEP) r_d.step = wr_data;
        if (rd_en && sel == W_TOP) begin
            r_d.shadow     = mid_live;
            r_d.shadow_vld = 1'b1;
        end else if (rd_en && sel == W_MID) begin
            r_d.shadow_vld = 1'b0;
        end
        if (ld_low || ld_mid || ld_top) r_d.shadow_vld = 1'b0;
    end

    always_comb begin
        rd_data = '0;
        case (sel)
            W_LOW:   rd_data[LOW_W-1:0] = time_ns[LOW_W-1:0];
            W_MID:   rd_data = r_q.shadow_vld ? r_q.shadow : mid_live;
            W_TOP:   rd_data[TOP_W-1:0] = time_ns[NS_W-1:LOW_W+MID_W];
            default: rd_data = r_q.step;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.step       <= STEP_RST;
            r_q.shadow     <= '0;
            r_q.shadow_vld <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // R8: upper bits of the top-field read are zero
    p_top_rd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == W_TOP) |-> rd_data[DATA_W-1:TOP_W] == '0);

    // R10: a top-field read captures the live middle field
    p_shadow_cap_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == W_TOP && !wr_en) |=>
        (r_q.shadow == $past(mid_live)) && r_q.shadow_vld);

    // R11: a step write is stored for the next edge
    p_step_load_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == W_STEP) |=> step == $past(wr_data));
endmodule

// File: rtl/tod_nco_counter.sv
module tod_nco_counter
    import tod_pkg::*;
#(
    parameter logic [31:0] STEP_RST = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  reg_word,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic [43:0] time_ns
);
    logic [STEP_W-1:0] step;
    logic              ld_low, ld_mid, ld_top;
    logic [LOW_W-1:0]  low_val;
    logic [MID_W-1:0]  mid_val;
    logic [TOP_W-1:0]  top_val;

    tod_regif #(.STEP_RST(STEP_RST)) u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .reg_word(reg_word), .wr_data(wr_data), .time_ns(time_ns),
        .rd_data(rd_data), .step(step), .ld_low(ld_low), .ld_mid(ld_mid),
        .ld_top(ld_top), .low_val(low_val), .mid_val(mid_val), .top_val(top_val)
    );

    tod_accum u_accum (
        .clk(clk), .rst(rst), .step(step), .ld_low(ld_low), .ld_mid(ld_mid),
        .ld_top(ld_top), .low_val(low_val), .mid_val(mid_val),
        .top_val(top_val), .time_ns(time_ns)
    );

    // R4: the 8 ns nominal step from the all-ones value wraps to 7
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (time_ns == 44'hFFF_FFFF_FFFF && step == 32'h8000_0000 &&
         !ld_low && !ld_mid && !ld_top) |=> time_ns == 44'd7);
endmodule

// File: tb/tod_nco_counter_bench.sv
module tod_nco_counter_bench;
    localparam time CLK_PERIOD = 8ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  reg_word = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [43:0] time_ns;
    int checks = 0;
    int errors = 0;

    tod_nco_counter u_tod_nco_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_word(reg_word),
        .wr_data(wr_data), .rd_data(rd_data), .time_ns(time_ns)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic bus_write(input logic [1:0] w, input logic [31:0] d);
        wr_en = 1'b1; reg_word = w; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] w, output logic [31:0] d);
        rd_en = 1'b1; reg_word = w;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_frozen(input logic [43:0] t);
        bus_write(2'd3, 32'h0);
        bus_write(2'd0, {28'h0, t[3:0]});
        bus_write(2'd1, t[35:4]);
        bus_write(2'd2, {16'h0, t[43:36], 8'h0});
    endtask

    task automatic do_reset();
        logic [31:0] d;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check("R1 time after reset", 64'(time_ns), 64'd0);
        bus_read(2'd3, d);
        check("R1 step after reset", 64'(d), 64'h8000_0000);
    endtask

    task automatic t_nominal();
        logic [43:0] t0;
        t0 = time_ns;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            check("R2 nominal advance", 64'(time_ns), 64'(t0 + 44'(8*i)));
        end
    endtask

    task automatic t_fraction();
        set_frozen(44'd0);
        bus_write(2'd3, 32'h8800_0000);
        check("R11 step write lags one edge", 64'(time_ns), 64'd0);
        @(negedge clk); check("R3 frac 8.5 step 1", 64'(time_ns), 64'd8);
        @(negedge clk); check("R3 frac 8.5 step 2", 64'(time_ns), 64'd17);
        @(negedge clk); check("R3 frac 8.5 step 3", 64'(time_ns), 64'd25);
        bus_write(2'd0, 32'hFFFF_FFF3);
        check("R6 low write value", 64'(time_ns), 64'd19);
        @(negedge clk);
        check("R6 fraction cleared by low write", 64'(time_ns), 64'd27);
    endtask

    task automatic t_wrap();
        set_frozen(44'hFFF_FFFF_FFFF);
        check("R8 R7 R6 field writes compose", 64'(time_ns), 64'hFFF_FFFF_FFFF);
        bus_write(2'd3, 32'h8000_0000);
        check("R11 old zero step used on write edge", 64'(time_ns), 64'hFFF_FFFF_FFFF);
        @(negedge clk);
        check("R4 wrap to 7", 64'(time_ns), 64'd7);
    endtask

    task automatic t_freeze_and_fields();
        logic [31:0] d;
        set_frozen(44'hAB1_2345_6789);
        repeat (3) @(negedge clk);
        check("R5 frozen with zero step", 64'(time_ns), 64'hAB1_2345_6789);
        bus_read(2'd2, d);
        check("R8 top read in low byte", 64'(d), 64'hAB);
        bus_read(2'd1, d);
        check("R7 middle read", 64'(d), 64'h1234_5678);
        bus_read(2'd0, d);
        check("R6 low read upper zero", 64'(d), 64'h9);
        bus_write(2'd3, 32'h8000_0000);
        check("R5 held until step takes effect", 64'(time_ns), 64'hAB1_2345_6789);
        @(negedge clk);
        check("R5 resume from held value", 64'(time_ns), 64'hAB1_2345_6791);
    endtask

    task automatic t_override();
        logic [43:0] t0;
        logic [43:0] exp;
        t0 = time_ns;
        bus_write(2'd1, 32'hDEAD_BEEF);
        exp = {t0[43:36], 32'hDEAD_BEEF, t0[3:0]};
        check("R9 R7 middle write replaces step", 64'(time_ns), 64'(exp));
        @(negedge clk);
        check("R9 counting continues", 64'(time_ns), 64'(exp + 44'd8));
    endtask

    task automatic t_shadow();
        logic [31:0] d;
        logic [31:0] snap;
        set_frozen(44'h012_0000_0000);
        bus_write(2'd3, 32'h8000_0000);
        snap = time_ns[35:4];
        bus_read(2'd2, d);
        repeat (10) @(negedge clk);
        bus_read(2'd1, d);
        check("R10 middle returns snapshot", 64'(d), 64'(snap));
        #1;
        snap = time_ns[35:4];
        bus_read(2'd1, d);
        check("R10 second middle read is live", 64'(d), 64'(snap));
        bus_read(2'd2, d);
        bus_write(2'd0, 32'h0);
        #1;
        snap = time_ns[35:4];
        bus_read(2'd1, d);
        check("R10 time write drops snapshot", 64'(d), 64'(snap));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_nominal();
        t_override();
        t_fraction();
        t_wrap();
        t_freeze_and_fields();
        t_shadow();
        do_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule